// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block is a clocked single-port memory. The address width is a parameter, and each 36-bit word is made of four 9-bit byte lanes. Every address, data and control input is captured on the rising clock edge. A host starts an access by raising one of two start strobes. The captured address then drives the storage array directly, and the read word reaches the output port in the same cycle. No output register sits on that path.

After a start, a 2-bit counter supplies the low two address bits for the following beats. The counter moves only in cycles where the step input is high and no strobe is taken. The counter's order is either linear or interleaved, chosen by a mode input. A write covers any subset of the lanes, or all of them at once through a write-all input. Three select inputs must all be high for a start to select the block. The bidirectional data bus is modelled as separate in and out ports, together with a drive-enable output.

Top module: `burst_sram_ft`

## Requirements
- R1: While `rst` is high, and after its release until the first start, `dq_oe` is 0.
- R2: A start taken on `strobe_cpu` with all three selects high is a read. After that edge, `dq_out` shows the word at `addr`, and `dq_oe` follows `out_en`.
- R3: With `mode` = 0, beat i of a burst reads or writes offset (start + i) mod 4 in address bits [1:0]. The upper bits are unchanged.
- R4: With `mode` = 1, beat i uses offset start XOR i in bits [1:0]. The upper bits are unchanged.
- R5: In a cycle with no strobe taken and `step` low, the burst address does not change, so the same word is accessed again.
- R6: Lane k is bits [9k+8:9k]. When `wr_all` is low, lane k is written only when `lane_en` and `lane_wr[k]` are both high. With `lane_en` low, nothing is written.
- R7: When `wr_all` is high, all four lanes are written, whatever `lane_en` and `lane_wr` hold.
- R8: A start taken while any select is low deselects the block in one cycle. `dq_oe` is 0 from the next edge, it stays 0 while `step` is high, and nothing is written.
- R9: `strobe_cpu` is ignored while `sel_a` is low. An active burst then continues as if no strobe were present.
- R10: When both strobes are taken together, `strobe_cpu` wins. The cycle is a read, and the write inputs are ignored.
- R11: `dq_oe` is high only in a selected read cycle with `out_en` high. It is low in write cycles, and `dq_out` is 0 whenever `dq_oe` is low.
- R12: A start on `strobe_ctl` writes when any lane would be written. Otherwise it reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address captured at a start |
| strobe_cpu | input | 1 | Read start strobe, gated by sel_a |
| strobe_ctl | input | 1 | Start strobe that may begin a write, lower priority |
| step | input | 1 | Advance the burst counter |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| sel_a | input | 1 | Primary select, active high |
| sel_b | input | 1 | Second select, active high |
| sel_c | input | 1 | Third select, active high |
| wr_all | input | 1 | Write all four lanes |
| lane_en | input | 1 | Qualifier for the per-lane write bits |
| lane_wr | input | 4 | Per-lane write bits |
| out_en | input | 1 | Output enable, acts without a clock |
| dq_in | input | 36 | Write data |
| dq_out | output | 36 | Read data, flow-through |
| dq_oe | output | 1 | Drive-enable for the data bus |

## Verification
The assertions are evaluated on every cycle. They check the following:
- The drive-enable is low under reset.
- It never rises without `out_en`.
- It matches `out_en` after a processor start.
- It falls after a deselecting start or a write-all start.
- The read word holds steady over a hold cycle.

Which address each beat reaches in the two burst orders, and which lanes a write really changed, show up only when the bench reads the data back against its own model. The same applies to the strobe priority and the gating by `sel_a`.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    parameter int LANES  = 4;
    parameter int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;

    typedef struct packed {
        cyc_e             kind;
        logic [LANES-1:0] mask;
    } cyc_t;

    // Low two address bits for beat cnt of a burst from offset start.
    function automatic logic [1:0] burst_off(input logic [1:0] start,
                                             input logic [1:0] cnt,
                                             input logic       ilv);
        logic [1:0] r;
        r = ilv ? (start ^ cnt) : (start + cnt);
        return r;
    endfunction
endpackage

// File: rtl/bsram_burst_ctrl.sv
module bsram_burst_ctrl
    import bsram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic              strobe_cpu,
    input  logic              strobe_ctl,
    input  logic              step,
    input  logic              mode,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              sel_c,
    input  logic              wr_all,
    input  logic              lane_en,
    input  logic [LANES-1:0]  lane_wr,
    input  logic [WORD_W-1:0] dq_in,
    output cyc_t              cyc,
    output logic [AW-1:0]     cur_addr,
    output logic [WORD_W-1:0] wdata
);
    logic [AW-1:0]    base_q;
    logic [1:0]       cnt_q;
    logic             ilv_q;
    cyc_t             cyc_q;
    logic             sel_all, cpu_go, load;
    logic [LANES-1:0] in_mask;

    always_comb begin
        sel_all = sel_a & sel_b & sel_c;
        cpu_go  = strobe_cpu & sel_a;
        load    = cpu_go | strobe_ctl;
        if (wr_all)       in_mask = '1;
        else if (lane_en) in_mask = lane_wr;
        else              in_mask = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q     <= '0;
            cnt_q      <= '0;
            ilv_q      <= 1'b0;
            cyc_q.kind <= CYC_IDLE;
            cyc_q.mask <= '0;
            wdata      <= '0;
        end else begin
            wdata <= dq_in;
            ilv_q <= mode;
            if (load) begin
                if (sel_all) begin
                    base_q <= addr;
                    cnt_q  <= '0;
                    if (cpu_go) begin
                        cyc_q.kind <= CYC_READ;
                        cyc_q.mask <= '0;
                    end else begin
                        cyc_q.kind <= (|in_mask) ? CYC_WRITE : CYC_READ;
                        cyc_q.mask <= in_mask;
                    end
                end else begin
                    cyc_q.kind <= CYC_IDLE;
                    cyc_q.mask <= '0;
                end
            end else if (cyc_q.kind != CYC_IDLE) begin
                if (step) cnt_q <= cnt_q + 2'd1;
                cyc_q.kind <= (|in_mask) ? CYC_WRITE : CYC_READ;
                cyc_q.mask <= in_mask;
            end
        end
    end

    assign cyc      = cyc_q;
    assign cur_addr = {base_q[AW-1:2], burst_off(base_q[1:0], cnt_q, ilv_q)};
endmodule

// File: rtl/bsram_array.sv
module bsram_array
    import bsram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic [LANES-1:0]  we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we[k]) mem[waddr] <= wdata[k*LANE_W +: LANE_W];
        end
        assign rdata[k*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/burst_sram_ft.sv
module burst_sram_ft
    import bsram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic              strobe_cpu,
    input  logic              strobe_ctl,
    input  logic              step,
    input  logic              mode,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              sel_c,
    input  logic              wr_all,
    input  logic              lane_en,
    input  logic [3:0]        lane_wr,
    input  logic              out_en,
    input  logic [35:0]       dq_in,
    output logic [35:0]       dq_out,
    output logic              dq_oe
);
    cyc_t              cyc;
    logic [AW-1:0]     cur_addr;
    logic [WORD_W-1:0] wdata, rdata;
    logic [LANES-1:0]  we;

    bsram_burst_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst(rst), .addr(addr),
        .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl), .step(step),
        .mode(mode), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
        .wr_all(wr_all), .lane_en(lane_en), .lane_wr(lane_wr),
        .dq_in(dq_in), .cyc(cyc), .cur_addr(cur_addr), .wdata(wdata)
    );

    assign we = (cyc.kind == CYC_WRITE) ? cyc.mask : '0;

    bsram_array #(.AW(AW)) u_mem (
        .clk(clk), .we(we), .waddr(cur_addr), .wdata(wdata),
        .raddr(cur_addr), .rdata(rdata)
    );

    assign dq_oe  = (cyc.kind == CYC_READ) & out_en;
    assign dq_out = dq_oe ? rdata : '0;
endmodule

// File: rtl/bsram_checker.sv
module bsram_checker (
    input logic        clk,
    input logic        rst,
    input logic        strobe_cpu,
    input logic        strobe_ctl,
    input logic        step,
    input logic        sel_a,
    input logic        sel_b,
    input logic        sel_c,
    input logic        wr_all,
    input logic        lane_en,
    input logic [3:0]  lane_wr,
    input logic        out_en,
    input logic [35:0] dq_out,
    input logic        dq_oe
);
    logic sel_all, cpu_go, taken, any_wr;
    assign sel_all = sel_a & sel_b & sel_c;
    assign cpu_go  = strobe_cpu & sel_a;
    assign taken   = cpu_go | strobe_ctl;
    assign any_wr  = wr_all | (lane_en & (|lane_wr));

    // R1: no drive while in reset
    p_quiet_reset_r1: assert property (@(posedge clk) rst |=> !dq_oe);

    // R2: processor start gives a read that follows out_en
    p_cpu_read_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_go && sel_all) |=> (dq_oe == out_en));

    // R8: deselecting start removes drive next cycle
    p_deselect_r8: assert property (@(posedge clk) disable iff (rst)
        (taken && !sel_all) |=> !dq_oe);

    // R7: write-all start via controller strobe is a write, no drive
    p_write_all_r7: assert property (@(posedge clk) disable iff (rst)
        (strobe_ctl && !cpu_go && sel_all && wr_all) |=> !dq_oe);

    // R11: drive never without out_en
    p_oe_gate_r11: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> out_en);

    // R5: a hold cycle repeats the same word
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && !taken && !step && !any_wr) |=> (dq_oe -> $stable(dq_out)));
endmodule

bind burst_sram_ft bsram_checker u_chk (
    .clk(clk), .rst(rst), .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl),
    .step(step), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
    .wr_all(wr_all), .lane_en(lane_en), .lane_wr(lane_wr), .out_en(out_en),
    .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/sim_burst_sram_ft.sv
`timescale 1ns/1ps
module sim_burst_sram_ft;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  addr;
    logic        strobe_cpu, strobe_ctl, step, mode;
    logic        sel_a, sel_b, sel_c, wr_all, lane_en, out_en;
    logic [3:0]  lane_wr;
    logic [35:0] dq_in, dq_out;
    logic        dq_oe;

    logic [35:0] model [256];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    burst_sram_ft #(.AW(8)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .strobe_cpu(strobe_cpu),
        .strobe_ctl(strobe_ctl), .step(step), .mode(mode), .sel_a(sel_a),
        .sel_b(sel_b), .sel_c(sel_c), .wr_all(wr_all), .lane_en(lane_en),
        .lane_wr(lane_wr), .out_en(out_en), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe)
    );

    function automatic logic [7:0] baddr(input logic [7:0] b, input int i, input logic md);
        logic [1:0] c = i[1:0];
        logic [1:0] o = md ? (b[1:0] ^ c) : (b[1:0] + c);
        return {b[7:2], o};
    endfunction

    function automatic logic [3:0] mask_of(input logic wa, input logic le, input logic [3:0] lw);
        return wa ? 4'hF : (le ? lw : 4'h0);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_read(input logic [7:0] a, input string tag);
        chk(dq_oe === 1'b1 && dq_out === model[a], tag, dq_out, model[a]);
    endtask

    task automatic beat(input logic cpu, input logic ctl, input logic stp,
                        input logic [7:0] a, input logic md, input logic wa,
                        input logic le, input logic [3:0] lw, input logic [35:0] d);
        @(negedge clk);
        strobe_cpu = cpu; strobe_ctl = ctl; step = stp; addr = a; mode = md;
        wr_all = wa; lane_en = le; lane_wr = lw; dq_in = d;
        @(posedge clk);
        #1;
    endtask

    task automatic apply(input logic [7:0] a, input logic [3:0] m, input logic [35:0] d);
        for (int l = 0; l < 4; l++)
            if (m[l]) model[a][l*9 +: 9] = d[l*9 +: 9];
    endtask

    task automatic write_burst(input logic [7:0] b, input logic md, input bit full);
        for (int i = 0; i < 4; i++) begin
            logic wa = full ? 1'b1 : (($urandom % 8) == 0);
            logic le = $urandom % 2;
            logic [3:0] lw = $urandom % 16;
            logic [35:0] d = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
            logic [3:0] m = mask_of(wa, le, lw);
            logic [7:0] a = baddr(b, i, md);
            beat(0, i == 0, i != 0, b, md, wa, le, lw, d);
            if (m != 4'h0) begin
                apply(a, m, d);
                chk(dq_oe === 1'b0 && dq_out === 36'h0, wa ? "R7/R11 write cycle" : "R6/R11 write cycle",
                    {35'h0, dq_oe}, 36'h0);
            end else begin
                expect_read(a, "R12 controller start without lanes reads");
            end
        end
    endtask

    task automatic read_burst(input logic [7:0] b, input logic md, input bit cpu);
        for (int i = 0; i < 4; i++) begin
            beat(cpu && i == 0, !cpu && i == 0, i != 0, b, md, 0, 0, 4'h0, 36'h0);
            if (i == 0) expect_read(b, "R2 start read");
            else expect_read(baddr(b, i, md), md ? "R4 interleaved beat" : "R3 linear beat");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 36'h1, 36'h0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; addr = 0; strobe_cpu = 0; strobe_ctl = 0; step = 0; mode = 0;
        sel_a = 1; sel_b = 1; sel_c = 1; wr_all = 0; lane_en = 0; lane_wr = 0;
        out_en = 1; dq_in = 0;
        repeat (3) @(posedge clk);
        #1 chk(dq_oe === 1'b0, "R1 reset", {35'h0, dq_oe}, 36'h0);
        @(negedge clk) rst = 0;
        @(posedge clk); #1;
        chk(dq_oe === 1'b0, "R1 after reset", {35'h0, dq_oe}, 36'h0);

        for (int b = 0; b < 256; b += 4) write_burst(b[7:0], 0, 1);

        // R5 hold
        beat(1, 0, 0, 8'h21, 0, 0, 0, 4'h0, 36'h0); expect_read(8'h21, "R2 start");
        beat(0, 0, 0, 8'h00, 0, 0, 0, 4'h0, 36'h0); expect_read(8'h21, "R5 hold");
        beat(0, 0, 1, 8'h00, 0, 0, 0, 4'h0, 36'h0); expect_read(8'h22, "R5 step after hold");

        // R9 processor strobe gated by sel_a
        beat(1, 0, 0, 8'h42, 1, 0, 0, 4'h0, 36'h0); expect_read(8'h42, "R2 start");
        sel_a = 0;
        beat(1, 0, 1, 8'h80, 1, 0, 0, 4'h0, 36'h0); expect_read(8'h43, "R9 ignored strobe");
        sel_a = 1;

        // R10 priority
        beat(1, 1, 0, 8'h60, 0, 1, 1, 4'hF, 36'h1_2345_6789); expect_read(8'h60, "R10 priority read");
        beat(1, 0, 0, 8'h60, 0, 0, 0, 4'h0, 36'h0); expect_read(8'h60, "R10 no write");

        // R8 deselect
        sel_b = 0;
        beat(0, 1, 0, 8'h64, 0, 1, 0, 4'h0, 36'hA_AAAA_AAAA);
        chk(dq_oe === 1'b0, "R8 deselect", {35'h0, dq_oe}, 36'h0);
        beat(0, 0, 1, 8'h64, 0, 0, 0, 4'h0, 36'h0);
        chk(dq_oe === 1'b0, "R8 stays deselected", {35'h0, dq_oe}, 36'h0);
        sel_b = 1; sel_c = 0;
        beat(1, 0, 0, 8'h64, 0, 0, 0, 4'h0, 36'h0);
        chk(dq_oe === 1'b0, "R8 third select", {35'h0, dq_oe}, 36'h0);
        sel_c = 1;
        beat(1, 0, 0, 8'h64, 0, 0, 0, 4'h0, 36'h0); expect_read(8'h64, "R8 nothing written");

        // R11 output enable
        out_en = 0;
        beat(1, 0, 0, 8'h70, 0, 0, 0, 4'h0, 36'h0);
        chk(dq_oe === 1'b0 && dq_out === 36'h0, "R11 out_en low", dq_out, 36'h0);
        out_en = 1; #1;
        expect_read(8'h70, "R11 out_en high");

        // R6 lane_en low writes nothing
        beat(0, 1, 0, 8'h74, 0, 0, 0, 4'hF, 36'h5_5555_5555); expect_read(8'h74, "R6 lane_en low");
        beat(1, 0, 0, 8'h74, 0, 0, 0, 4'h0, 36'h0); expect_read(8'h74, "R6 unchanged");
        // R6 partial lanes
        beat(0, 1, 0, 8'h78, 0, 0, 1, 4'b0101, 36'h3_C3C3_C3C3); apply(8'h78, 4'b0101, 36'h3_C3C3_C3C3);
        beat(1, 0, 0, 8'h78, 0, 0, 0, 4'h0, 36'h0); expect_read(8'h78, "R6 lanes 0 and 2");
        // R7 override
        beat(0, 1, 0, 8'h7C, 0, 1, 0, 4'h0, 36'h9_8765_4321); apply(8'h7C, 4'hF, 36'h9_8765_4321);
        beat(1, 0, 0, 8'h7C, 0, 0, 0, 4'h0, 36'h0); expect_read(8'h7C, "R7 all lanes");

        for (int n = 0; n < 200; n++) begin
            logic [7:0] b = $urandom % 256;
            logic md = $urandom % 2;
            if ($urandom % 2) write_burst(b, md, 0);
            else read_burst(b, md, $urandom % 2);
        end
        for (int b = 0; b < 256; b += 4) read_burst(b[7:0] + (b[3:2]), b[2], b[3]);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule